// File: doc/BRIEF.md
# SDRAM Refresh and Clock-Enable Controller

This block models the device-side handling of refresh and clock enable in a multi-bank SDRAM. A refresh command issued while every bank is closed opens and then closes one row in all banks together. An internal counter picks that row, and the counter advances once per completed refresh. While the refresh runs, the block is busy for a number of clocks set on an input, and it accepts no other command.

What a low clock enable means depends on the device state. If the device is idle, with no bank open and no refresh running, a low clock enable puts it into power-down until the enable rises again. If a bank is open or a refresh is running, a low clock enable freezes the internal state in place. A refresh command given together with a low clock enable puts the device into self-refresh. In self-refresh an on-chip timer issues refresh cycles by itself, and the device stays there until the clock enable returns high.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: After reset the row counter is 0, the controller is idle, and every output strobe and status flag is low.
- R2: A refresh request taken while idle, with the clock enable high and no bank open, drives the activate strobe of every bank high for exactly one cycle, starting in the cycle after the request edge. The refresh-busy flag rises in that same cycle.
- R3: Busy lasts `refCycles` cycles, with 0 treated as 1. In the cycle after the last busy cycle, the precharge strobe of every bank is high for one cycle and busy is low.
- R4: `refRow` holds the row being refreshed. It increments by one in the cycle in which the precharge strobes appear, and it wraps from 2^ROW_W-1 (8191 by default) to 0.
- R5: A refresh request while any bank is open, whatever the clock enable, raises `refErr` for one cycle. It issues no strobe and leaves `refRow` unchanged.
- R6: Refresh requests that arrive while busy are ignored. They cause no extra strobe and do not lengthen busy.
- R7: A low clock enable while idle with no bank open, and with no refresh request, sets `powerDown` from the next cycle. It stays set, ignoring refresh requests, until the edge at which the clock enable is high; it clears after that edge.
- R8: A low clock enable while busy freezes the busy count and `refRow`, and shows `frozen` in the following cycle. A low clock enable while idle with a bank open shows `frozen` and does not enter power-down.
- R9: A refresh request with the clock enable low and no bank open sets `selfRefresh` from the next cycle. `selfRefresh` clears after the first edge at which the clock enable is high and no internal precharge is pending.
- R10: In self-refresh, the activate strobes fire SR_INTERVAL edges after entry. The precharge strobes and the row increment follow one cycle later, and the sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| refreshReq | input | 1 | Refresh command, sampled each edge |
| bankOpen | input | NUM_BANKS | One bit per bank, high while that bank holds an open row |
| refCycles | input | BUSY_W | Length of the refresh busy period in clocks |
| actStb | output | NUM_BANKS | Per-bank activate strobe for the counted row |
| preStb | output | NUM_BANKS | Per-bank precharge strobe for the counted row |
| refRow | output | ROW_W | Internal refresh row counter |
| refBusy | output | 1 | Auto-refresh in progress |
| refErr | output | 1 | One-cycle pulse on a rejected refresh request |
| powerDown | output | 1 | Device in power-down |
| selfRefresh | output | 1 | Device in self-refresh |
| frozen | output | 1 | State held because the clock enable was low while not idle |

## Verification
The assertions assume that `bankOpen` reports the banks truthfully and that `refCycles` stays constant while a refresh runs. The stimulus changes `refCycles` only while the controller is idle. It raises bank-open bits only in cycles meant to test rejection or freezing. It drives every input at the falling clock edge, so each request is seen at exactly one rising edge.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REFRESH = 2'd1,
    ST_PWRDN   = 2'd2,
    ST_SELFREF = 2'd3
  } refState_t;

  typedef struct packed {
    logic loadBusy;
    logic decBusy;
    logic fireAct;
    logic firePre;
    logic srTick;
    logic srClr;
  } ctlStb_t;
endpackage

// File: rtl/sdram_refresh_datapath.sv
module sdram_refresh_datapath
  import sdram_refresh_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 13,
  parameter int BUSY_W      = 8,
  parameter int SR_INTERVAL = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStb_t              stb,
  input  logic [BUSY_W-1:0]    refCycles,
  output logic                 busyLast,
  output logic                 srExpire,
  output logic [NUM_BANKS-1:0] actStb,
  output logic [NUM_BANKS-1:0] preStb,
  output logic [ROW_W-1:0]     refRow
);
  localparam int SR_W = (SR_INTERVAL > 2) ? $clog2(SR_INTERVAL) : 1;
  localparam logic [SR_W-1:0] SR_LAST = SR_W'(SR_INTERVAL - 1);

  logic [BUSY_W-1:0] busyCnt;
  logic [BUSY_W-1:0] loadVal;
  logic [SR_W-1:0]   srTimer;

  assign loadVal  = (refCycles == '0) ? BUSY_W'(1) : refCycles;
  assign busyLast = (busyCnt == BUSY_W'(1));
  assign srExpire = (srTimer == SR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (stb.loadBusy) begin
      busyCnt <= loadVal;
    end else if (stb.decBusy) begin
      busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.srClr) begin
      srTimer <= '0;
    end else if (stb.srTick) begin
      srTimer <= srExpire ? '0 : srTimer + SR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refRow <= '0;
    end else if (stb.firePre) begin
      refRow <= refRow + ROW_W'(1);
    end
  end

  // one strobe register per bank; all banks see the same command
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actStb[b] <= 1'b0;
        preStb[b] <= 1'b0;
      end else begin
        actStb[b] <= stb.fireAct;
        preStb[b] <= stb.firePre;
      end
    end
  end
endmodule

// File: rtl/sdram_refresh_control.sv
module sdram_refresh_control
  import sdram_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cke,
  input  logic    refreshReq,
  input  logic    anyOpen,
  input  logic    busyLast,
  input  logic    srExpire,
  output ctlStb_t stb,
  output logic    refBusy,
  output logic    refErr,
  output logic    powerDown,
  output logic    selfRefresh,
  output logic    frozen
);
  refState_t state, stateNxt;
  logic srPend, srPendNxt, errNxt, frzNxt;

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    srPendNxt = srPend;
    errNxt    = 1'b0;
    frzNxt    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (refreshReq) begin
          if (anyOpen) begin
            errNxt = 1'b1;
          end else if (!cke) begin
            stateNxt  = ST_SELFREF;
            stb.srClr = 1'b1;
          end else begin
            stateNxt     = ST_REFRESH;
            stb.loadBusy = 1'b1;
            stb.fireAct  = 1'b1;
          end
        end else if (!cke) begin
          if (anyOpen) frzNxt = 1'b1;
          else         stateNxt = ST_PWRDN;
        end
      end
      ST_REFRESH: begin
        if (!cke) begin
          frzNxt = 1'b1;
        end else if (busyLast) begin
          stb.firePre = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          stb.decBusy = 1'b1;
        end
      end
      ST_PWRDN: begin
        if (cke) stateNxt = ST_IDLE;
      end
      ST_SELFREF: begin
        if (srPend) begin
          stb.firePre = 1'b1;
          srPendNxt   = 1'b0;
        end else if (cke) begin
          stateNxt = ST_IDLE;
        end else if (srExpire) begin
          stb.fireAct = 1'b1;
          stb.srTick  = 1'b1;
          srPendNxt   = 1'b1;
        end else begin
          stb.srTick = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      srPend <= 1'b0;
      refErr <= 1'b0;
      frozen <= 1'b0;
    end else begin
      state  <= stateNxt;
      srPend <= srPendNxt;
      refErr <= errNxt;
      frozen <= frzNxt;
    end
  end

  assign refBusy     = (state == ST_REFRESH);
  assign powerDown   = (state == ST_PWRDN);
  assign selfRefresh = (state == ST_SELFREF);
endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
  import sdram_refresh_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 13,
  parameter int BUSY_W      = 8,
  parameter int SR_INTERVAL = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 refreshReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [BUSY_W-1:0]    refCycles,
  output logic [NUM_BANKS-1:0] actStb,
  output logic [NUM_BANKS-1:0] preStb,
  output logic [ROW_W-1:0]     refRow,
  output logic                 refBusy,
  output logic                 refErr,
  output logic                 powerDown,
  output logic                 selfRefresh,
  output logic                 frozen
);
  ctlStb_t stb;
  logic    busyLast, srExpire;

  sdram_refresh_control u_ctl (
    .clk(clk), .rstN(rstN), .cke(cke), .refreshReq(refreshReq),
    .anyOpen(|bankOpen), .busyLast(busyLast), .srExpire(srExpire),
    .stb(stb), .refBusy(refBusy), .refErr(refErr), .powerDown(powerDown),
    .selfRefresh(selfRefresh), .frozen(frozen)
  );

  sdram_refresh_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BUSY_W(BUSY_W), .SR_INTERVAL(SR_INTERVAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .refCycles(refCycles),
    .busyLast(busyLast), .srExpire(srExpire),
    .actStb(actStb), .preStb(preStb), .refRow(refRow)
  );
endmodule

// File: rtl/sdram_refresh_ctrl_checker.sv
module sdram_refresh_ctrl_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cke,
  input logic [NUM_BANKS-1:0] actStb,
  input logic [NUM_BANKS-1:0] preStb,
  input logic [ROW_W-1:0]     refRow,
  input logic                 refBusy,
  input logic                 refErr,
  input logic                 powerDown,
  input logic                 selfRefresh
);
  assert_act_all_banks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|actStb) |-> ((&actStb) && (refBusy || selfRefresh) && !(|preStb)));

  assert_pre_after_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|preStb) |-> ((&preStb) && !refBusy));

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|preStb) |-> (refRow == ROW_W'($past(refRow) + 1'b1)));

  assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    refErr |-> (!(|actStb) && !refBusy));

  assert_pd_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && cke) |=> !powerDown);

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refBusy && !cke) |=> (refBusy && $stable(refRow)));

  assert_modes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({powerDown, selfRefresh, refBusy}) <= 1);

  assert_sr_pre_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|actStb) && selfRefresh) |=> (|preStb));
endmodule

bind sdram_refresh_ctrl sdram_refresh_ctrl_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .actStb(actStb), .preStb(preStb),
  .refRow(refRow), .refBusy(refBusy), .refErr(refErr),
  .powerDown(powerDown), .selfRefresh(selfRefresh)
);

// File: tb/sdram_refresh_ctrl_bench.sv
module sdram_refresh_ctrl_bench;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int BW = 8;
  localparam int SRI = 64;
  localparam int NSTEP = 18;

  // {cke, req, open, expAct, expPre, expBusy, expErr, expPd, expSr, expFrz}
  localparam logic [9:0] VEC [NSTEP] = '{
    10'b110_1010000,  // R2 accept
    10'b100_0010000,  // R3 busy
    10'b100_0010000,  // R3 busy
    10'b100_0100000,  // R3 precharge
    10'b111_0001000,  // R5 reject
    10'b100_0000000,  // R5 idle after
    10'b000_0000100,  // R7 power-down
    10'b010_0000100,  // R7 request ignored
    10'b100_0000000,  // R7 exit
    10'b001_0000001,  // R8 open bank freeze
    10'b100_0000000,  // R8 release
    10'b110_1010000,  // R2 accept
    10'b000_0010001,  // R8 frozen busy
    10'b000_0010001,  // R8 frozen busy
    10'b110_0010000,  // R6 request ignored
    10'b100_0010000,  // R6 busy
    10'b100_0100000,  // R3 precharge
    10'b100_0000000   // R3 idle
  };

  logic clk = 1'b0, rstN = 1'b0, cke = 1'b1, refreshReq = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic [BW-1:0] refCycles = BW'(3);
  logic [NB-1:0] actStb, preStb;
  logic [RW-1:0] refRow;
  logic refBusy, refErr, powerDown, selfRefresh, frozen;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_refresh_ctrl #(.NUM_BANKS(NB), .ROW_W(RW), .BUSY_W(BW), .SR_INTERVAL(SRI)) u_sdram_refresh_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .refreshReq(refreshReq), .bankOpen(bankOpen),
    .refCycles(refCycles), .actStb(actStb), .preStb(preStb), .refRow(refRow),
    .refBusy(refBusy), .refErr(refErr), .powerDown(powerDown),
    .selfRefresh(selfRefresh), .frozen(frozen)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0, 11:       return "R2";
      1, 2, 3, 16, 17: return "R3";
      4, 5:        return "R5";
      6, 7, 8:     return "R7";
      9, 10, 12, 13: return "R8";
      default:     return "R6";
    endcase
  endfunction

  function automatic logic [6:0] outVec();
    return {&actStb, &preStb, refBusy, refErr, powerDown, selfRefresh, frozen};
  endfunction

  task automatic drive(input logic c, input logic r, input logic [NB-1:0] o);
    @(negedge clk);
    cke = c; refreshReq = r; bankOpen = o;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    int cnt;
    int rowExp;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 outputs", {actStb, preStb, refBusy, refErr, powerDown, selfRefresh, frozen}, 0);
    check("R1 row", refRow, 0);

    for (int i = 0; i < NSTEP; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7] ? NB'(4) : '0);
      check(tagOf(i), outVec(), VEC[i][6:0]);
      if (VEC[i][6]) check("R4 row at activate", refRow, (i == 0) ? 0 : 1);
    end
    check("R4 row after two refreshes", refRow, 2);

    // R3: zero busy length is treated as one
    refCycles = '0;
    drive(1'b1, 1'b1, '0);
    check("R3 zero len busy", refBusy, 1);
    drive(1'b1, 1'b0, '0);
    check("R3 zero len pre", {&preStb, refBusy}, 2'b10);
    check("R4 row 3", refRow, 3);

    // R9/R10 self-refresh entry and internal cycles
    drive(1'b0, 1'b1, '0);
    check("R9 enter", selfRefresh, 1);
    cnt = 0;
    while (!(|actStb) && cnt < 200) begin
      drive(1'b0, 1'b0, '0);
      cnt++;
    end
    check("R10 interval", cnt, SRI);
    drive(1'b0, 1'b0, '0);
    check("R10 pre follows", {&preStb, selfRefresh}, 2'b11);
    check("R10 row step", refRow, 4);
    drive(1'b1, 1'b0, '0);
    check("R9 exit", {selfRefresh, powerDown}, 0);

    // R4 wrap at 8191 -> 0
    refCycles = BW'(1);
    rowExp = 4;
    while (rowExp != 0) begin
      drive(1'b1, 1'b1, '0);
      drive(1'b1, 1'b0, '0);
      rowExp = (rowExp + 1) % (1 << RW);
      if (rowExp == (1 << RW) - 1) check("R4 last row", refRow, (1 << RW) - 1);
    end
    check("R4 wrap to zero", refRow, 0);

    // R5: rejection with cke low leaves self-refresh untouched
    drive(1'b0, 1'b1, NB'(1));
    check("R5 reject cke low", {refErr, selfRefresh, powerDown}, 3'b100);
    check("R5 row kept", refRow, 0);

    // R1 reset mid-refresh
    refCycles = BW'(5);
    drive(1'b1, 1'b1, '0);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears busy", {refBusy, refRow}, 0);
    finishRun();
  end
endmodule